// File: doc/BRIEF.md
# Sv32 Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It does this by reading a two-level page table through a simple memory port. A request carries the address, the access kind and the privilege state in force. The walker works out the effective mode and either bypasses translation or walks the table. Each entry it reads is checked in a fixed order. It marks the leaf entry as accessed, and also as dirty on a store, using a compare-and-swap write. It then returns one response: either a fault, or the physical address together with read, write and execute permission bits.

The memory port takes a request that lasts one cycle. It answers with a one-cycle acknowledge, one or more cycles later. A write is a compare-and-swap: memory stores `mem_wdata` only if the word still equals `mem_cmp`, and always returns the word it held before. `mem_err` on a write acknowledge means the target cannot be written. `mem_err` is ignored on reads.

Top module: `sv32_walker`

## Requirements
- R1: When the effective mode is machine (`req_priv`=3 and the MPRV substitution below does not apply), the response returns `rsp_paddr` equal to the zero-extended virtual address, permissions r=w=x=1 and no fault. No memory access is made.
- R2: With `xlat_on`=0, every request bypasses translation in the same way as R1, whatever the privilege.
- R3: For loads (`req_acc`=1) and stores (`req_acc`=2) made in machine mode with `mprv`=1, the effective mode is `mpp`. Fetches (`req_acc`=0) always use `req_priv`. Privilege codes are 0 user, 1 supervisor, 3 machine.
- R4: The first entry is read from the word address {`root_ppn`, va[31:22], 2'b00}. A pointer entry leads to a read at {ppn, va[21:12], 2'b00}. A 4 KiB leaf yields {ppn, va[11:0]}. The entry layout is V=bit0, R=1, W=2, X=3, U=4, A=6, D=7, with the ppn in bits 31:10.
- R5: A leaf found at the first level is a 4 MiB superpage mapping to {ppn[21:10], va[21:0]}. If ppn[9:0] is not zero, the request faults.
- R6: The request faults if V is clear, if W is set without R, or if a pointer entry (R=W=X=0) appears at the second level.
- R7: A page with U set faults from a non-user mode, unless `sum`=1 and the access is not a fetch. A page with U clear faults unless the mode is supervisor.
- R8: A load needs R, or X with `mxr`=1. A store needs W. A fetch needs X. An access that fails these checks faults.
- R9: A leaf that lacks A (or lacks D, for a store) is written back with only those bits added, using the entry as read as the compare value. No write is made when the bits are already set.
- R10: If the compare-and-swap returns a word other than the entry as read, the walk restarts from the root and uses the new contents.
- R11: A write acknowledged with `mem_err`=1 makes the request fault.
- R12: The permissions returned are r = R or (X and `mxr`), x = X, and w = W and (store or D).
- R13: Each accepted request produces exactly one `rsp_valid` pulse. `req_ready` is high only while idle. A fault returns a zero address and zero permissions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Current privilege, 0 U, 1 S, 3 M |
| mprv | input | 1 | Substitute `mpp` for machine-mode data accesses |
| mpp | input | 2 | Previous privilege |
| sum | input | 1 | Allow supervisor data access to user pages |
| mxr | input | 1 | Execute-only pages readable |
| xlat_on | input | 1 | 1 = Sv32 translation, 0 = bare |
| root_ppn | input | 22 | Root table page number |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a compare-and-swap write |
| mem_addr | output | 34 | Entry physical address |
| mem_wdata | output | 32 | New entry value |
| mem_cmp | output | 32 | Expected current value |
| mem_ack | input | 1 | Memory reply |
| mem_rdata | input | 32 | Word read, or prior value on a write |
| mem_err | input | 1 | Write target not writable |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read permitted |
| rsp_w | output | 1 | Write permitted |
| rsp_x | output | 1 | Execute permitted |

## Verification
The assertions check, on every cycle, the shape of the handshakes and of the outputs. Responses and memory requests are single pulses and never overlap. Entry addresses are word aligned. A write-back differs from its compare value only in the A and D bits and always sets A. A fault carries zero address and permissions, and write permission never appears without read. The fault order, the mode substitution, superpage address splicing, the result of permission checks, and restarts after a lost compare-and-swap depend on the table contents. Only the bench scenarios show those, with a bench-owned memory holding prepared tables and able to inject interference or refuse writes.

// File: rtl/sv32_walker.sv
module sv32_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic [1:0]  req_priv,
  input  logic        mprv,
  input  logic [1:0]  mpp,
  input  logic        sum,
  input  logic        mxr,
  input  logic        xlat_on,
  input  logic [21:0] root_ppn,
  output logic        mem_req,
  output logic        mem_we,
  output logic [33:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [31:0] mem_cmp,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [33:0] rsp_paddr,
  output logic        rsp_r,
  output logic        rsp_w,
  output logic        rsp_x
);
  localparam logic [1:0] ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2;
  localparam logic [1:0] MODE_U = 2'd0, MODE_S = 2'd1, MODE_M = 2'd3;
  localparam logic [31:0] BIT_A = 32'h40, BIT_D = 32'h80;

  typedef enum logic [2:0] {IDLE, READ_PTE, WAIT_PTE, CHECK, WRITE_AD, DONE} st_t;
  st_t st;

  logic [31:0] va, pte;
  logic [21:0] base, root_q;
  logic [1:0]  acc, mode;
  logic        lvl, wr_phase, sum_q, mxr_q;

  wire is_fetch = acc == ACC_FETCH;
  wire is_load  = acc == ACC_LOAD;
  wire is_store = acc == ACC_STORE;
  wire pv = pte[0], pr = pte[1], pw = pte[2], px = pte[3], pu = pte[4];
  wire [21:0] ppn = pte[31:10];
  wire [9:0]  idx = lvl ? va[31:22] : va[21:12];
  wire        is_ptr = pv && !(pr || pw || px);
  wire [1:0]  eff_in = (req_priv == MODE_M && req_acc != ACC_FETCH && mprv) ? mpp : req_priv;
  wire [31:0] upd = pte | BIT_A | (is_store ? BIT_D : 32'h0);

  wire [33:0] ok_paddr = lvl ? {upd[31:20], va[21:0]} : {upd[31:10], va[11:0]};
  wire ok_r = upd[1] || (upd[3] && mxr_q);
  wire ok_w = upd[2] && (is_store || upd[7]);
  wire ok_x = upd[3];

  logic fail;
  always_comb begin
    fail = 1'b0;
    if (!pv)                                         fail = 1'b1;
    else if (is_ptr)                                 fail = !lvl;
    else if (pw && !pr)                              fail = 1'b1;
    else if (pu && mode != MODE_U && (!sum_q || is_fetch)) fail = 1'b1;
    else if (!pu && mode != MODE_S)                  fail = 1'b1;
    else if (lvl && ppn[9:0] != 10'd0)               fail = 1'b1;
    else if (is_load && !(pr || (px && mxr_q)))      fail = 1'b1;
    else if (is_store && !pw)                        fail = 1'b1;
    else if (is_fetch && !px)                        fail = 1'b1;
  end

  assign req_ready = st == IDLE;
  assign rsp_valid = st == DONE;
  assign mem_req   = st == READ_PTE || st == WRITE_AD;
  assign mem_we    = st == WRITE_AD;
  assign mem_addr  = {base, idx, 2'b00};
  assign mem_wdata = upd;
  assign mem_cmp   = pte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; va <= '0; pte <= '0; base <= '0; root_q <= '0;
      acc <= '0; mode <= '0; lvl <= 1'b0; wr_phase <= 1'b0; sum_q <= 1'b0; mxr_q <= 1'b0;
      rsp_fault <= 1'b0; rsp_paddr <= '0; rsp_r <= 1'b0; rsp_w <= 1'b0; rsp_x <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va <= req_vaddr; acc <= req_acc; mode <= eff_in;
          sum_q <= sum; mxr_q <= mxr; root_q <= root_ppn; base <= root_ppn;
          lvl <= 1'b1; wr_phase <= 1'b0;
          if (eff_in == MODE_M || !xlat_on) begin
            rsp_fault <= 1'b0; rsp_paddr <= {2'b00, req_vaddr};
            rsp_r <= 1'b1; rsp_w <= 1'b1; rsp_x <= 1'b1;
            st <= DONE;
          end else st <= READ_PTE;
        end
        READ_PTE: st <= WAIT_PTE;
        WRITE_AD: st <= WAIT_PTE;
        WAIT_PTE: if (mem_ack) begin
          if (!wr_phase) begin
            pte <= mem_rdata;
            st  <= CHECK;
          end else begin
            wr_phase <= 1'b0;
            if (mem_err) begin
              rsp_fault <= 1'b1; rsp_paddr <= '0;
              rsp_r <= 1'b0; rsp_w <= 1'b0; rsp_x <= 1'b0;
              st <= DONE;
            end else if (mem_rdata != pte) begin
              base <= root_q; lvl <= 1'b1;
              st <= READ_PTE;
            end else begin
              pte <= upd;
              rsp_fault <= 1'b0; rsp_paddr <= ok_paddr;
              rsp_r <= ok_r; rsp_w <= ok_w; rsp_x <= ok_x;
              st <= DONE;
            end
          end
        end
        CHECK: begin
          if (fail) begin
            rsp_fault <= 1'b1; rsp_paddr <= '0;
            rsp_r <= 1'b0; rsp_w <= 1'b0; rsp_x <= 1'b0;
            st <= DONE;
          end else if (is_ptr) begin
            base <= ppn; lvl <= 1'b0;
            st <= READ_PTE;
          end else if (upd != pte) begin
            wr_phase <= 1'b1;
            st <= WRITE_AD;
          end else begin
            rsp_fault <= 1'b0; rsp_paddr <= ok_paddr;
            rsp_r <= ok_r; rsp_w <= ok_w; rsp_x <= ok_x;
            st <= DONE;
          end
        end
        DONE: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sv32_walker_chk.sv
module sv32_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [33:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_cmp,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [33:0] rsp_paddr,
  input logic        rsp_r,
  input logic        rsp_w,
  input logic        rsp_x
);
  assert_single_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_idle_after_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  assert_busy_not_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !req_ready);
  assert_mem_oneshot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  assert_ad_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[6] && mem_wdata != mem_cmp &&
      (mem_wdata | 32'hC0) == (mem_cmp | 32'hC0)));
  assert_fault_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == 34'd0 && !rsp_r && !rsp_w && !rsp_x));
  assert_w_implies_r_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_w) |-> rsp_r);
endmodule

bind sv32_walker sv32_walker_chk u_chk (.*);

// File: tb/sv32_walker_tb.sv
module sv32_walker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_ready, mprv = 0, sum = 0, mxr = 0, xlat_on = 1;
  logic [31:0] req_vaddr = 0;
  logic [1:0] req_acc = 0, req_priv = 0, mpp = 0;
  logic [21:0] root_ppn = 22'h1;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_cmp, mem_rdata;
  logic rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [33:0] rsp_paddr;

  sv32_walker u_dut (.*);

  logic [31:0] mem [0:4095];
  logic cfg_we = 0, ro = 0;
  logic [11:0] cfg_idx = 0;
  logic [31:0] cfg_data = 0, intf_val = 0;
  int intf_req = 0, intf_done = 0, nrd = 0, nwr = 0;
  logic pend = 0, pwe = 0;
  logic [33:0] pa = 0;
  logic [31:0] pwd = 0, pcmp = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0; mem_err <= 1'b0;
    if (cfg_we) mem[cfg_idx] <= cfg_data;
    if (pend) begin
      pend <= 1'b0; mem_ack <= 1'b1;
      if (!pwe) begin
        mem_rdata <= mem[pa[13:2]]; nrd <= nrd + 1;
      end else if (ro) begin
        mem_err <= 1'b1; mem_rdata <= mem[pa[13:2]];
      end else if (intf_req != intf_done) begin
        intf_done <= intf_req; mem[pa[13:2]] <= intf_val; mem_rdata <= intf_val;
      end else begin
        mem_rdata <= mem[pa[13:2]];
        if (mem[pa[13:2]] == pcmp) begin mem[pa[13:2]] <= pwd; nwr <= nwr + 1; end
      end
    end
    if (mem_req) begin pend <= 1'b1; pwe <= mem_we; pa <= mem_addr; pwd <= mem_wdata; pcmp <= mem_cmp; end
  end

  int checks = 0, failures = 0;
  logic g_fault; logic [33:0] g_pa; logic [2:0] g_rwx;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] i, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = i; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [31:0] ent(input logic [21:0] p, input logic [9:0] f);
    return {p, f};
  endfunction

  task automatic run(input logic [31:0] va, input logic [1:0] acc, input logic [1:0] pr);
    int n;
    @(negedge clk);
    req_vaddr = va; req_acc = acc; req_priv = pr; req_valid = 1;
    @(negedge clk); req_valid = 0;
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (!rsp_valid) begin
      checks++; failures++;
      $display("FAIL R13 watchdog actual=no_response expected=response");
    end
    g_fault = rsp_fault; g_pa = rsp_paddr; g_rwx = {rsp_r, rsp_w, rsp_x};
    @(negedge clk);
    chk("R13 single pulse", rsp_valid, 0);
  endtask

  task automatic expect_ok(input string req, input logic [33:0] p, input logic [2:0] rwx);
    chk(req, {g_fault, g_pa, g_rwx}, {1'b0, p, rwx});
  endtask
  task automatic expect_fault(input string req);
    chk(req, {g_fault, g_pa, g_rwx}, {1'b1, 34'd0, 3'd0});
  endtask

  task automatic t_reset;
    chk("R13 reset ready", req_ready, 1);
    chk("R13 reset rsp", rsp_valid, 0);
    chk("R13 reset mem", mem_req, 0);
  endtask

  task automatic t_bypass;
    int r0;
    r0 = nrd;
    xlat_on = 1; run(32'hDEADB0EF, 2'd2, 2'd3);
    expect_ok("R1 machine bypass", 34'h0DEADB0EF, 3'b111);
    chk("R1 no memory read", nrd - r0, 0);
    xlat_on = 0; run(32'h80001234, 2'd0, 2'd0);
    expect_ok("R2 bare bypass", 34'h080001234, 3'b111);
    chk("R2 no memory read", nrd - r0, 0);
    xlat_on = 1;
  endtask

  task automatic t_walk;
    int r0;
    poke(12'h401, ent(22'h2, 10'h001));
    poke(12'h803, ent(22'h12345, 10'h0C7));
    r0 = nrd;
    fork
      run(32'h00403123, 2'd1, 2'd1);
      begin repeat (3) @(negedge clk); chk("R13 busy not ready", req_ready, 0); end
    join
    expect_ok("R4 4K walk", 34'h012345123, 3'b110);
    chk("R4 two reads", nrd - r0, 2);
    run(32'h00403123, 2'd1, 2'd0);
    expect_fault("R7 S page from U");
  endtask

  task automatic t_mprv;
    mprv = 1; mpp = 2'd1;
    run(32'h00403123, 2'd1, 2'd3);
    expect_ok("R3 mprv load uses S", 34'h012345123, 3'b110);
    run(32'h00403123, 2'd0, 2'd3);
    expect_ok("R3 fetch ignores mprv", 34'h000403123, 3'b111);
    mpp = 2'd0;
    run(32'h00403123, 2'd2, 2'd3);
    expect_fault("R3 mprv store as U on S page");
    mprv = 0;
  endtask

  task automatic t_super;
    poke(12'h405, ent(22'h000C00, 10'h04B));
    poke(12'h406, ent(22'h000C01, 10'h04B));
    run(32'h0142A456, 2'd0, 2'd1);
    expect_ok("R5 superpage", 34'h000C2A456, 3'b101);
    run(32'h01800000, 2'd0, 2'd1);
    expect_fault("R5 misaligned superpage");
  endtask

  task automatic t_invalid;
    poke(12'h804, 32'h0);
    poke(12'h805, ent(22'h10, 10'h045));
    poke(12'h806, ent(22'h10, 10'h04D));
    poke(12'h807, ent(22'h2, 10'h001));
    run(32'h00404000, 2'd1, 2'd1); expect_fault("R6 V clear");
    run(32'h00405000, 2'd2, 2'd1); expect_fault("R6 W without R");
    run(32'h00406000, 2'd0, 2'd1); expect_fault("R6 W and X without R");
    run(32'h00407000, 2'd1, 2'd1); expect_fault("R6 pointer at last level");
  endtask

  task automatic t_user;
    poke(12'h808, ent(22'h111, 10'h0DF));
    sum = 0; run(32'h00408000, 2'd1, 2'd1); expect_fault("R7 U page from S no sum");
    sum = 1; run(32'h00408010, 2'd1, 2'd1); expect_ok("R7 U page from S with sum", 34'h000111010, 3'b111);
    run(32'h00408000, 2'd0, 2'd1); expect_fault("R7 fetch U page from S with sum");
    sum = 0; run(32'h00408000, 2'd0, 2'd0); expect_ok("R7 U fetch", 34'h000111000, 3'b111);
  endtask

  task automatic t_perm;
    poke(12'h809, ent(22'h222, 10'h049));
    poke(12'h80A, ent(22'h333, 10'h043));
    mxr = 0; run(32'h00409000, 2'd1, 2'd1); expect_fault("R8 load X-only no mxr");
    mxr = 1; run(32'h00409000, 2'd1, 2'd1); expect_ok("R8 R12 load X-only mxr", 34'h000222000, 3'b101);
    mxr = 0; run(32'h00409000, 2'd2, 2'd1); expect_fault("R8 store no W");
    run(32'h0040A000, 2'd0, 2'd1); expect_fault("R8 fetch no X");
    run(32'h0040A000, 2'd1, 2'd1); expect_ok("R8 R12 load R-only", 34'h000333000, 3'b100);
  endtask

  task automatic t_ad;
    int w0;
    poke(12'h80B, ent(22'h444, 10'h007));
    poke(12'h80C, ent(22'h555, 10'h007));
    w0 = nwr;
    run(32'h0040B000, 2'd2, 2'd1);
    expect_ok("R9 R12 store sets A D", 34'h000444000, 3'b110);
    chk("R9 store writeback", mem[12'h80B], ent(22'h444, 10'h0C7));
    run(32'h0040C000, 2'd1, 2'd1);
    expect_ok("R12 clean page load no w", 34'h000555000, 3'b100);
    chk("R9 load sets A only", mem[12'h80C], ent(22'h555, 10'h047));
    chk("R9 two writes", nwr - w0, 2);
    run(32'h0040C000, 2'd1, 2'd1);
    chk("R9 no write when A set", nwr - w0, 2);
  endtask

  task automatic t_retry;
    int r0;
    poke(12'h80D, ent(22'h666, 10'h007));
    @(negedge clk); intf_val = ent(22'h777, 10'h007); intf_req = intf_req + 1;
    r0 = nrd;
    run(32'h0040D000, 2'd2, 2'd1);
    expect_ok("R10 restart uses new entry", 34'h000777000, 3'b110);
    chk("R10 four reads", nrd - r0, 4);
    chk("R10 final entry", mem[12'h80D], ent(22'h777, 10'h0C7));
  endtask

  task automatic t_ro;
    poke(12'h80E, ent(22'h888, 10'h007));
    @(negedge clk); ro = 1;
    run(32'h0040E000, 2'd1, 2'd1);
    expect_fault("R11 non-writable");
    chk("R11 entry unchanged", mem[12'h80E], ent(22'h888, 10'h007));
    @(negedge clk); ro = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_bypass;
    t_walk;
    t_mprv;
    t_super;
    t_invalid;
    t_user;
    t_perm;
    t_ad;
    t_retry;
    t_ro;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule